// File: doc/BRIEF.md
# Queued SPI Slave Burst Responder

This block is an SPI target (mode 0: MOSI sampled on the rising SCK edge, MISO changed on the falling edge, most significant bit first). It serves whole bursts from a bus controller without help from the local host. The host side has two queues. The host pushes bytes into a transmit queue. It pops bytes that the controller sent from a receive queue. Both queues are circular memories of 256 entries with wrapping 8-bit indices, so each holds at most 255 bytes.

When chip select falls, the block first sends the current transmit-queue occupancy. The controller can use this count to plan its next requests. After that, each completed byte does three things: it stores the received byte, it presents the next queued transmit byte (or zero if none is left), and it starts fetching the byte for the slot after that. A transmit byte leaves the queue only when all of its bits have been clocked out. A byte that was fetched ahead but never sent stays queued for the next burst.

The SPI pins are sampled in the system clock domain through two-flop synchronisers. SCK must therefore be well below the system clock; one SCK phase should last at least six system clocks.

Top module: `spiq_burst_slave`

## Requirements
- R1: In the first byte of a burst, MISO carries the transmit occupancy at the moment select falls. The occupancy is the write index minus the read index, modulo 256.
- R2: The following bytes of the burst are the queued transmit bytes in push order, most significant bit first. Each byte is presented before the first rising SCK edge of its slot.
- R3: If no queued byte is left at a byte boundary, the next outgoing byte is 0x00.
- R4: A transmit byte is removed only after all 8 of its bits have been transferred. A byte that was prefetched, or only partly shifted out when select rose, is sent again in a later burst.
- R5: Every complete 8-bit byte received on MOSI enters the receive queue in arrival order. A partial byte cut off by select rising is discarded.
- R6: While select is high, MISO is held at 0. Raising select ends the burst.
- R7: The transmit queue holds at most 255 bytes. `tx_ready` is low when it is full, and a push offered then is not accepted.
- R8: A byte completed while the receive queue holds 255 bytes is dropped. This sets `rx_ovf`, which stays set until `ovf_clr` is pulsed.
- R9: Both queue indices wrap past 255. The occupancy byte stays correct when the write index has wrapped and the read index has not.
- R10: After reset, MISO is 0, `tx_ready` is 1, `rx_valid` is 0 and `rx_ovf` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock from the controller |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller |
| tx_valid | input | 1 | Host offers a byte for the transmit queue |
| tx_data | input | 8 | Byte to enqueue |
| tx_ready | output | 1 | Transmit queue has room |
| rx_valid | output | 1 | Receive queue holds a byte |
| rx_data | output | 8 | Oldest received byte |
| rx_ready | input | 1 | Host takes the byte on rx_data |
| rx_ovf | output | 1 | Sticky receive-overflow flag |
| ovf_clr | input | 1 | Clears rx_ovf |

## Verification
Most wrong internal state in this block appears in the next burst's first byte. If the committed read index moved too early or too late, the occupancy count sent when select next falls is wrong, and so is the data byte that follows it. A prefetch pointer that fails to advance shows up within the current burst, as a repeated byte one slot later. Receive-side faults appear as soon as the host pops: a byte is missing, duplicated or out of order. A lost overflow flag is visible at once on `rx_ovf`.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
    // Raw SPI input pins, grouped so they can share one synchroniser.
    typedef struct packed {
        logic cs_n;
        logic sck;
        logic mosi;
    } spi_pins_t;

    localparam int PIN_W = $bits(spi_pins_t);
    localparam spi_pins_t PIN_IDLE = '{cs_n: 1'b1, sck: 1'b0, mosi: 1'b0};
endpackage

// File: rtl/spiq_sync.sv
module spiq_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] st_d [STAGES];
    logic [W-1:0] st_q [STAGES];

    always_comb begin
        st_d[0] = din;
        for (int i = 1; i < STAGES; i++) st_d[i] = st_q[i-1];
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q[g] <= RST_VAL;
            else        st_q[g] <= st_d[g];
        end
    end

    assign dout = st_q[STAGES-1];
endmodule

// File: rtl/spiq_ring.sv
module spiq_ring #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          rd_load,
    input  logic [AW-1:0] rd_next,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic          full
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [DW-1:0] mem [DEPTH];
    logic          wr_ok;

    always_comb begin
        full  = (AW'(ptr_q.wr + 1'b1) == ptr_q.rd);
        wr_ok = push && !full;
        ptr_d = ptr_q;
        if (wr_ok)   ptr_d.wr = ptr_q.wr + 1'b1;
        if (rd_load) ptr_d.rd = rd_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[ptr_q.wr] <= push_data;
    end

    assign rdata  = mem[raddr];
    assign wr_ptr = ptr_q.wr;
    assign rd_ptr = ptr_q.rd;
endmodule

// File: rtl/spiq_burst_slave.sv
module spiq_burst_slave #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_sck,
    input  logic          spi_cs_n,
    input  logic          spi_mosi,
    output logic          spi_miso,
    input  logic          tx_valid,
    input  logic [DW-1:0] tx_data,
    output logic          tx_ready,
    output logic          rx_valid,
    output logic [DW-1:0] rx_data,
    input  logic          rx_ready,
    output logic          rx_ovf,
    input  logic          ovf_clr
);
    import spiq_pkg::*;

    localparam int BCW = $clog2(DW);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);

    typedef struct packed {
        logic           active;
        logic [BCW-1:0] bitcnt;
        logic [DW-1:0]  txsh;
        logic [DW-1:0]  rxsh;
        logic [DW-1:0]  nxt;     // prefetched byte for the following slot
        logic [AW-1:0]  fetch;   // index after the prefetched byte
        logic [AW-1:0]  commit;  // read index once the current byte completes
        logic           ovf;
        logic           cs_prev;
        logic           sck_prev;
    } st_t;

    st_t st_d, st_q;

    spi_pins_t     pins_raw, pins_s;
    logic          cs_s, sck_s, mosi_s;
    logic          done;
    logic [DW-1:0] rx_byte;
    logic [AW-1:0] tx_raddr, tx_wr, tx_rd, rx_wr, rx_rd;
    logic [DW-1:0] tx_rdata;
    logic          tx_full, rx_full, rx_push, rx_pop;

    assign pins_raw = '{cs_n: spi_cs_n, sck: spi_sck, mosi: spi_mosi};

    spiq_sync #(.W(PIN_W), .STAGES(2), .RST_VAL(PIN_IDLE)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .dout (pins_s)
    );

    assign cs_s   = pins_s.cs_n;
    assign sck_s  = pins_s.sck;
    assign mosi_s = pins_s.mosi;

    spiq_ring #(.DW(DW), .AW(AW)) u_txq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (tx_valid),
        .push_data(tx_data),
        .rd_load  (done),
        .rd_next  (st_q.commit),
        .raddr    (tx_raddr),
        .rdata    (tx_rdata),
        .wr_ptr   (tx_wr),
        .rd_ptr   (tx_rd),
        .full     (tx_full)
    );

    spiq_ring #(.DW(DW), .AW(AW)) u_rxq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rx_push),
        .push_data(rx_byte),
        .rd_load  (rx_pop),
        .rd_next  (AW'(rx_rd + 1'b1)),
        .raddr    (rx_rd),
        .rdata    (rx_data),
        .wr_ptr   (rx_wr),
        .rd_ptr   (rx_rd),
        .full     (rx_full)
    );

    always_comb begin
        st_d          = st_q;
        st_d.cs_prev  = cs_s;
        st_d.sck_prev = sck_s;
        done          = 1'b0;
        tx_raddr      = st_q.fetch;
        rx_byte       = {st_q.rxsh[DW-2:0], mosi_s};

        if (cs_s) begin
            // deselected: end of burst, output register cleared
            st_d.active = 1'b0;
            st_d.txsh   = '0;
            st_d.bitcnt = '0;
        end else if (st_q.cs_prev) begin
            // select just fell: occupancy first, prefetch the head byte
            tx_raddr     = tx_rd;
            st_d.active  = 1'b1;
            st_d.bitcnt  = '0;
            st_d.rxsh    = '0;
            st_d.txsh    = DW'(AW'(tx_wr - tx_rd));
            st_d.commit  = tx_rd;
            st_d.nxt     = (tx_rd != tx_wr) ? tx_rdata : '0;
            st_d.fetch   = tx_rd + AW'(tx_rd != tx_wr);
        end else if (st_q.active) begin
            if (sck_s && !st_q.sck_prev) begin
                st_d.rxsh   = rx_byte;
                st_d.bitcnt = st_q.bitcnt + 1'b1;
                if (st_q.bitcnt == LAST_BIT) begin
                    done        = 1'b1;
                    st_d.bitcnt = '0;
                    st_d.txsh   = st_q.nxt;
                    st_d.commit = st_q.fetch;
                    st_d.nxt    = (st_q.fetch != tx_wr) ? tx_rdata : '0;
                    st_d.fetch  = st_q.fetch + AW'(st_q.fetch != tx_wr);
                end
            end else if (!sck_s && st_q.sck_prev && st_q.bitcnt != '0) begin
                st_d.txsh = {st_q.txsh[DW-2:0], 1'b0};
            end
        end

        rx_push = done && !rx_full;
        if (ovf_clr)            st_d.ovf = 1'b0;
        if (done && rx_full)    st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.cs_prev  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_valid = (rx_wr != rx_rd);
    assign rx_pop   = rx_valid && rx_ready;
    assign tx_ready = !tx_full;
    assign rx_ovf   = st_q.ovf;
    assign spi_miso = st_q.txsh[DW-1];
endmodule

// File: rtl/spiq_burst_chk.sv
module spiq_burst_chk #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          miso,
    input logic          cs_hi,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [AW-1:0] tx_wr,
    input logic [AW-1:0] tx_rd,
    input logic          byte_done,
    input logic          rx_valid,
    input logic          rx_ready,
    input logic [DW-1:0] rx_data,
    input logic          ovf,
    input logic          ovf_clr
);
    // R6
    idle_miso_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi && $past(cs_hi) |-> !miso);

    // R7
    full_push_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_wr == $past(tx_wr));

    // R4
    commit_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rd != $past(tx_rd) |-> $past(byte_done));

    // R5
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rx_ready |=> rx_valid && rx_data == $past(rx_data));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !ovf_clr |=> ovf);
endmodule

bind spiq_burst_slave spiq_burst_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .miso     (spi_miso),
    .cs_hi    (cs_s),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_wr    (tx_wr),
    .tx_rd    (tx_rd),
    .byte_done(done),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data),
    .ovf      (rx_ovf),
    .ovf_clr  (ovf_clr)
);

// File: tb/tb_spiq_burst_slave.sv
module tb_spiq_burst_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, miso;
    logic       tx_valid = 1'b0, tx_ready;
    logic [7:0] tx_data = '0;
    logic       rx_valid, rx_ready = 1'b0, rx_ovf, ovf_clr = 1'b0;
    logic [7:0] rx_data;

    int checks = 0, fails = 0, seq = 0;
    bit finished = 0;
    logic [7:0] mtx [1024];
    int mh = 0, mt = 0;

    // {pushes, first pushed value, burst length}
    localparam logic [23:0] VEC [6] = '{
        {8'd0,   8'h00, 8'd3},    // empty queue: count 0 then zeros
        {8'd5,   8'h10, 8'd3},    // shorter than queue
        {8'd0,   8'h00, 8'd4},    // remainder preserved
        {8'd0,   8'h00, 8'd2},    // drained again
        {8'd250, 8'h20, 8'd251},  // write index reaches 255
        {8'd10,  8'h80, 8'd11}    // write index wraps past 255
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    spiq_burst_slave dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_ready(rx_ready), .rx_ovf(rx_ovf),
        .ovf_clr(ovf_clr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic push_byte(input logic [7:0] d);
        @(negedge clk);
        tx_valid = 1'b1;
        tx_data  = d;
        if (mt - mh < 255) begin
            mtx[mt] = d;
            mt++;
        end
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] mo, output logic [7:0] got);
        for (int b = 7; b >= 0; b--) begin
            mosi = mo[b];
            repeat (HALF) @(negedge clk);
            got[b] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    // Runs a burst of whole bytes and checks both directions against the model.
    task automatic burst(input int len, input string first_req);
        int cnt, used, nstore;
        logic [7:0] sent [300];
        logic [7:0] got, mo, exp;
        cnt = mt - mh;
        cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int k = 0; k < len; k++) begin
            mo = 8'(seq * 37 + 5);
            seq++;
            sent[k] = mo;
            xfer(mo, got);
            if (k == 0) begin
                check(got == 8'(cnt), first_req, got, 8'(cnt));
            end else if (k - 1 < cnt) begin
                exp = mtx[mh + k - 1];
                check(got == exp, "R2", got, exp);
            end else begin
                check(got == 8'h00, "R3", got, 0);
            end
        end
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        check(miso == 1'b0, "R6", miso, 0);
        used = (len - 1 < cnt) ? len - 1 : cnt;
        mh += used;
        nstore = (len > 255) ? 255 : len;
        for (int k = 0; k < nstore; k++) begin
            @(negedge clk);
            check(rx_valid && rx_data == sent[k], "R5", rx_data, sent[k]);
            rx_ready = 1'b1;
            @(negedge clk);
            rx_ready = 1'b0;
        end
        @(negedge clk);
        check(rx_valid == 1'b0, "R5", rx_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=done");
        summary();
    end

    initial begin
        logic [7:0] got;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R10 reset state
        check(miso == 1'b0, "R10", miso, 0);
        check(tx_ready == 1'b1, "R10", tx_ready, 1);
        check(rx_valid == 1'b0, "R10", rx_valid, 0);
        check(rx_ovf == 1'b0, "R10", rx_ovf, 0);

        for (int v = 0; v < 6; v++) begin
            for (int p = 0; p < int'(VEC[v][23:16]); p++)
                push_byte(8'(int'(VEC[v][15:8]) + p));
            // vector 5: occupancy across the index wrap (R9)
            burst(int'(VEC[v][7:0]), (v == 5) ? "R9" : "R1");
        end
        check(rx_ovf == 1'b0, "R8", rx_ovf, 0);

        // R4: burst cut after 3 bits consumes nothing and stores nothing
        push_byte(8'hC1);
        push_byte(8'hC2);
        cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int b = 0; b < 3; b++) begin
            mosi = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        check(rx_valid == 1'b0, "R5", rx_valid, 0);
        check(miso == 1'b0, "R6", miso, 0);
        burst(3, "R4");

        // R7: fill the transmit queue to 255
        for (int p = 0; p < 255; p++) push_byte(8'(p * 3 + 1));
        @(negedge clk);
        check(tx_ready == 1'b0, "R7", tx_ready, 0);
        push_byte(8'hEE);   // refused by the design and by the model
        // R8: 256 received bytes overflow the 255-entry receive queue
        burst(256, "R7");
        check(rx_ovf == 1'b1, "R8", rx_ovf, 1);
        check(tx_ready == 1'b1, "R7", tx_ready, 1);
        @(negedge clk);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        @(negedge clk);
        check(rx_ovf == 1'b0, "R8", rx_ovf, 0);
        burst(2, "R1");
        got = '0;
        check(got == 8'h00 && mt == mh, "R3", mt - mh, 0);
        summary();
    end
endmodule